// File: doc/BRIEF.md
# Debug Domain Power-Down Sequencer

This controller switches a shared debug and trace power island on and off. The island holds logic on two unrelated clocks: a debug bus clock and a trace bus clock. A small state machine on a separate controller clock drives the sequence. The signals it controls are an active-low reset for each of the two clock domains, one output-clamp enable shared by both domains, and the enable of the island's power switch.

When the off request is raised, both domain resets are asserted. Each domain counts its own clock cycles while its reset is held low. When each count reaches the minimum, a done flag is passed back to the controller clock through a synchronizer. Only after both flags have arrived does the controller assert the clamp, and only after that does it cut power.

Power-up runs in the opposite order:
- power is applied;
- the synchronized power-good input is awaited;
- the clamp is released;
- both resets are released, each synchronized to its own clock.

A two-bit status output reports the island's condition. The off request is a level that is sampled only when the island is fully on or fully off.

Top module: `dbg_pwr_seq`

## Requirements
- R1: While and just after reset, both domain resets are low, the clamp is high, power is off and the status reads 2'b00 (off).
- R2: Raising the off request while powered pulls both domain resets low while the clamp is still low and power is still on.
- R3: The debug reset has been low for at least HOLD_CYC (default 8) debug-clock cycles when the clamp rises.
- R4: The trace reset has been low for at least HOLD_CYC (default 8) trace-clock cycles when the clamp rises.
- R5: The clamp rises only after both hold counts are complete, with power still on. Power is cut only after the clamp has been high for at least one controller cycle.
- R6: Both domain resets stay low for the whole time power is off.
- R7: On power-up, power is applied while the clamp is high and both resets are low. The clamp stays high until the power-good input has been seen high.
- R8: Each domain reset is released only while the clamp is low and power is on, and the sequence ends with status 2'b01 (powered).
- R9: Status encoding: 2'b00 off, 2'b01 powered, 2'b10 clamped with power on, 2'b11 a reset hold or a release is in progress.
- R10: A change of the off request while a sequence runs does not alter that sequence. The request level is acted on once the island is fully on or fully off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ctl_clk | input | 1 | Controller clock |
| dbg_clk | input | 1 | Debug bus clock |
| trc_clk | input | 1 | Trace bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per clock domain |
| off_req | input | 1 | Level request: 1 = island off, 0 = island on (controller clock) |
| pwr_good | input | 1 | Power-good from the supply switch, asynchronous |
| dbg_rst_n | output | 1 | Active-low reset of the debug domain |
| trc_rst_n | output | 1 | Active-low reset of the trace domain |
| clamp_en | output | 1 | Output clamp enable, high = clamped |
| pwr_en | output | 1 | Power switch enable |
| status | output | 2 | Island condition, encoded as in R9 |

## Verification
The two hold-count completions can land in the same controller cycle, or many cycles apart. The bench provokes both cases. It runs one pass with the trace clock much slower, one with the debug clock much slower, and one with equal debug and trace periods, so that both done flags cross into the controller together. In each pass the clamp rise is judged by the number of domain cycles each reset has been low, counted at the port.

A second collision is a withdrawn or reversed request that arrives during a running sequence. The bench toggles the request mid-sequence and checks that the running sequence completes before the new level is obeyed.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_PWRUP,
    ST_UNCLAMP,
    ST_RELEASE,
    ST_ON,
    ST_RSTWAIT,
    ST_CLAMP
  } dps_state_e;

  typedef enum logic [1:0] {
    STAT_OFF     = 2'b00,
    STAT_POWERED = 2'b01,
    STAT_CLAMPED = 2'b10,
    STAT_BUSY    = 2'b11
  } dps_stat_e;

endpackage

// File: rtl/dps_sync.sv
// Multi-stage synchronizer with a selectable reset value.
module dps_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= {STAGES{RST_VAL}};
    end else begin
      sr_q <= sr_d;
    end
  end

  assign q = sr_q[STAGES-1];

endmodule

// File: rtl/dps_hold.sv
// Per-domain reset driver with minimum-hold counter.
module dps_hold #(
  parameter int HOLD_CYC    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic dom_clk,
  input  logic rst_n,
  input  logic rst_req,
  output logic dom_rst_n,
  output logic hold_done
);

  localparam int              CNT_W   = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_CYC);

  logic             loc_rst_n;
  logic             req_s;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             dom_rst_n_d;

  // local reset: asserted asynchronously, released on dom_clk
  dps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(dom_clk), .rst_n(rst_n), .d(1'b1), .q(loc_rst_n)
  );

  dps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
    .clk(dom_clk), .rst_n(loc_rst_n), .d(rst_req), .q(req_s)
  );

  always_comb begin
    dom_rst_n_d = !req_s;
    cnt_en      = !dom_rst_n && (cnt_q != CNT_MAX);
    if (!req_s) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge dom_clk or negedge loc_rst_n) begin
    if (!loc_rst_n) begin
      dom_rst_n <= 1'b0;
      cnt_q     <= '0;
    end else begin
      dom_rst_n <= dom_rst_n_d;
      cnt_q     <= cnt_d;
    end
  end

  assign hold_done = (cnt_q == CNT_MAX);

  // R3 R4: a completed hold count always belongs to a reset still held low
  done_in_reset_chk: assert property (@(posedge dom_clk) disable iff (!loc_rst_n)
    hold_done |-> !dom_rst_n);

endmodule

// File: rtl/dbg_pwr_seq.sv
module dbg_pwr_seq #(
  parameter int HOLD_CYC    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       ctl_clk,
  input  logic       dbg_clk,
  input  logic       trc_clk,
  input  logic       rst_n,
  input  logic       off_req,
  input  logic       pwr_good,
  output logic       dbg_rst_n,
  output logic       trc_rst_n,
  output logic       clamp_en,
  output logic       pwr_en,
  output logic [1:0] status
);
  import dps_pkg::*;

  logic       ctl_rst_n;
  logic       pwr_good_s;
  logic       dbg_done, trc_done;
  logic       dbg_done_s, trc_done_s;
  logic       rst_req_q, rst_req_d;
  logic       clamp_d, pwr_d;
  logic [1:0] status_d;
  dps_state_e state_q, state_d;

  dps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ctl_rst (
    .clk(ctl_clk), .rst_n(rst_n), .d(1'b1), .q(ctl_rst_n)
  );
  dps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg_sync (
    .clk(ctl_clk), .rst_n(ctl_rst_n), .d(pwr_good), .q(pwr_good_s)
  );

  // one hold driver per clock domain of the island
  dps_hold #(.HOLD_CYC(HOLD_CYC), .SYNC_STAGES(SYNC_STAGES)) u_dbg_hold (
    .dom_clk(dbg_clk), .rst_n(rst_n), .rst_req(rst_req_q),
    .dom_rst_n(dbg_rst_n), .hold_done(dbg_done)
  );
  dps_hold #(.HOLD_CYC(HOLD_CYC), .SYNC_STAGES(SYNC_STAGES)) u_trc_hold (
    .dom_clk(trc_clk), .rst_n(rst_n), .rst_req(rst_req_q),
    .dom_rst_n(trc_rst_n), .hold_done(trc_done)
  );

  dps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dbg_done_sync (
    .clk(ctl_clk), .rst_n(ctl_rst_n), .d(dbg_done), .q(dbg_done_s)
  );
  dps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_trc_done_sync (
    .clk(ctl_clk), .rst_n(ctl_rst_n), .d(trc_done), .q(trc_done_s)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ON:      if (off_req) state_d = ST_RSTWAIT;
      ST_RSTWAIT: if (dbg_done_s && trc_done_s) state_d = ST_CLAMP;
      ST_CLAMP:   state_d = ST_OFF;
      ST_OFF:     if (!off_req && dbg_done_s && trc_done_s) state_d = ST_PWRUP;
      ST_PWRUP:   if (pwr_good_s) state_d = ST_UNCLAMP;
      ST_UNCLAMP: state_d = ST_RELEASE;
      ST_RELEASE: if (!dbg_done_s && !trc_done_s) state_d = ST_ON;
      default:    state_d = ST_OFF;
    endcase
  end

  // output decode of the next state, registered below
  always_comb begin
    rst_req_d = 1'b1;
    clamp_d   = 1'b0;
    pwr_d     = 1'b1;
    status_d  = STAT_BUSY;
    unique case (state_d)
      ST_ON:      begin rst_req_d = 1'b0; status_d = STAT_POWERED; end
      ST_RSTWAIT: status_d = STAT_BUSY;
      ST_CLAMP:   begin clamp_d = 1'b1; status_d = STAT_CLAMPED; end
      ST_OFF:     begin clamp_d = 1'b1; pwr_d = 1'b0; status_d = STAT_OFF; end
      ST_PWRUP:   begin clamp_d = 1'b1; status_d = STAT_CLAMPED; end
      ST_UNCLAMP: status_d = STAT_BUSY;
      ST_RELEASE: rst_req_d = 1'b0;
      default:    begin clamp_d = 1'b1; pwr_d = 1'b0; status_d = STAT_OFF; end
    endcase
  end

  always_ff @(posedge ctl_clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) begin
      state_q   <= ST_OFF;
      rst_req_q <= 1'b1;
      clamp_en  <= 1'b1;
      pwr_en    <= 1'b0;
      status    <= STAT_OFF;
    end else begin
      state_q   <= state_d;
      rst_req_q <= rst_req_d;
      clamp_en  <= clamp_d;
      pwr_en    <= pwr_d;
      status    <= status_d;
    end
  end

  // R5
  clamp_after_hold_chk: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    $rose(clamp_en) |-> (dbg_done_s && trc_done_s && pwr_en));
  // R5
  cut_after_clamp_chk: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    $fell(pwr_en) |-> $past(clamp_en));
  // R6
  unpowered_in_reset_chk: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    !pwr_en |-> (!dbg_rst_n && !trc_rst_n));
  // R7
  unclamp_after_good_chk: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    $fell(clamp_en) |-> ($past(pwr_good_s) && pwr_en));
  // R8
  clamped_in_reset_chk: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    clamp_en |-> (!dbg_rst_n && !trc_rst_n));

endmodule

// File: tb/dbg_pwr_seq_tb.sv
module dbg_pwr_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 8;
  localparam int TMO        = 5000;

  logic ctl_clk = 1'b0, dbg_clk = 1'b0, trc_clk = 1'b0;
  logic rst_n, off_req, pwr_good;
  logic dbg_rst_n, trc_rst_n, clamp_en, pwr_en;
  logic [1:0] status;

  int dbg_half = 7, trc_half = 23, pg_lat = 4, pg_cnt = 0;
  int dbg_low = 0, trc_low = 0;
  int checks = 0, failures = 0;
  bit mon_on = 1'b0;
  bit seen_off = 1'b0;

  always #(CLK_PERIOD/2) ctl_clk = ~ctl_clk;
  initial forever #(dbg_half) dbg_clk = ~dbg_clk;
  initial forever #(trc_half) trc_clk = ~trc_clk;

  dbg_pwr_seq #(.HOLD_CYC(HOLD)) u_dut (
    .ctl_clk(ctl_clk), .dbg_clk(dbg_clk), .trc_clk(trc_clk), .rst_n(rst_n),
    .off_req(off_req), .pwr_good(pwr_good), .dbg_rst_n(dbg_rst_n),
    .trc_rst_n(trc_rst_n), .clamp_en(clamp_en), .pwr_en(pwr_en), .status(status)
  );

  // supply model: power-good follows the switch after pg_lat cycles
  always @(posedge ctl_clk) begin
    if (!pwr_en) begin pg_cnt <= 0; pwr_good <= 1'b0; end
    else if (pg_cnt < pg_lat) pg_cnt <= pg_cnt + 1;
    else pwr_good <= 1'b1;
  end

  always @(posedge dbg_clk) dbg_low <= dbg_rst_n ? 0 : dbg_low + 1;
  always @(posedge trc_clk) trc_low <= trc_rst_n ? 0 : trc_low + 1;

  task automatic chk(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // port monitors for ordering
  initial forever begin
    @(posedge clamp_en);
    if (mon_on) begin
      chk("R3 debug hold cycles", dbg_low >= HOLD, dbg_low, HOLD);
      chk("R4 trace hold cycles", trc_low >= HOLD, trc_low, HOLD);
      chk("R5 power on at clamp", pwr_en == 1'b1, pwr_en, 1);
    end
  end
  initial forever begin
    @(negedge pwr_en);
    #1;
    seen_off = 1'b1;
    if (mon_on) begin
      chk("R5 clamp before cut", clamp_en == 1'b1, clamp_en, 1);
      chk("R6 resets low at cut", !dbg_rst_n && !trc_rst_n, {dbg_rst_n, trc_rst_n}, 0);
    end
  end
  initial forever begin
    @(posedge dbg_rst_n);
    #1;
    if (mon_on) chk("R8 debug release unclamped", !clamp_en && pwr_en, {clamp_en, pwr_en}, 1);
  end
  initial forever begin
    @(posedge trc_rst_n);
    #1;
    if (mon_on) chk("R8 trace release unclamped", !clamp_en && pwr_en, {clamp_en, pwr_en}, 1);
  end

  task automatic wait_status(logic [1:0] s, string req);
    int n = 0;
    while (status !== s && n < TMO) begin @(negedge ctl_clk); n++; end
    chk(req, status === s, status, s);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; off_req = 1'b1;
    repeat (3) @(negedge ctl_clk);
    chk("R1 reset state", {dbg_rst_n, trc_rst_n, clamp_en, pwr_en, status} == 6'b001000,
        {dbg_rst_n, trc_rst_n, clamp_en, pwr_en, status}, 6'b001000);
    rst_n = 1'b1;
    repeat (20) @(negedge ctl_clk);
    chk("R1 after reset", {clamp_en, pwr_en, status} == 4'b1000, {clamp_en, pwr_en, status}, 4'b1000);
    mon_on = 1'b1;
  endtask

  task automatic t_power_up(int lat);
    int n = 0;
    pg_lat = lat;
    @(negedge ctl_clk); off_req = 1'b0;
    while (!pwr_en && n < TMO) begin @(negedge ctl_clk); n++; end
    chk("R7 power applied clamped", pwr_en && clamp_en && !dbg_rst_n && !trc_rst_n,
        {pwr_en, clamp_en, dbg_rst_n, trc_rst_n}, 4'b1100);
    chk("R9 clamped status", status == 2'b10, status, 2'b10);
    if (lat > 20) begin
      repeat (20) @(negedge ctl_clk);
      chk("R7 clamp held without power-good", clamp_en == 1'b1, clamp_en, 1);
    end
    wait_status(2'b01, "R8 reaches powered");
    chk("R8 resets released", dbg_rst_n && trc_rst_n && !clamp_en,
        {dbg_rst_n, trc_rst_n, clamp_en}, 3'b110);
  endtask

  task automatic t_power_down;
    int n = 0;
    @(negedge ctl_clk); off_req = 1'b1;
    while ((dbg_rst_n || trc_rst_n) && n < TMO) begin @(negedge ctl_clk); n++; end
    chk("R2 resets before clamp", !clamp_en && pwr_en, {clamp_en, pwr_en}, 2'b01);
    chk("R9 busy status", status == 2'b11, status, 2'b11);
    wait_status(2'b00, "R9 off status");
    chk("R6 off outputs", {dbg_rst_n, trc_rst_n, clamp_en, pwr_en} == 4'b0010,
        {dbg_rst_n, trc_rst_n, clamp_en, pwr_en}, 4'b0010);
  endtask

  task automatic t_stay_off;
    bit bad = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge ctl_clk);
      if (dbg_rst_n || trc_rst_n || pwr_en) bad = 1'b1;
    end
    chk("R6 resets held while off", !bad, bad, 0);
  endtask

  task automatic t_withdraw;
    int n = 0;
    seen_off = 1'b0;
    @(negedge ctl_clk); off_req = 1'b1;
    repeat (2) @(negedge ctl_clk); off_req = 1'b0;
    while (!seen_off && n < TMO) begin @(negedge ctl_clk); n++; end
    chk("R10 withdrawn request still powers off", seen_off, seen_off, 1);
    wait_status(2'b01, "R10 level obeyed after off");
  endtask

  task automatic t_request_in_powerup;
    int n = 0;
    pg_lat = 30;
    @(negedge ctl_clk); off_req = 1'b0;
    while (!pwr_en && n < TMO) begin @(negedge ctl_clk); n++; end
    off_req = 1'b1;
    wait_status(2'b01, "R10 power-up completes despite request");
    wait_status(2'b00, "R10 then powers off");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    pwr_good = 1'b0;
    t_reset();
    // trace clock slow
    t_power_up(4);
    t_power_down();
    t_stay_off();
    // debug clock slow
    dbg_half = 23; trc_half = 7;
    t_power_up(40);
    t_power_down();
    // equal domain clocks: both done flags cross together
    dbg_half = 9; trc_half = 9;
    t_power_up(3);
    t_power_down();
    t_power_up(3);
    t_withdraw();
    t_power_down();
    t_request_in_powerup();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule